// File: doc/BRIEF.md
# Flag-Updating Byte Arithmetic Unit

This block is the arithmetic and logic stage of a small 8-bit core. Each accepted request carries an operation code and two byte operands, which may come from registers or from an immediate. For the word operations it also carries the high byte of a register pair. The block returns a result byte, or a result pair for word operations. It keeps a six-bit status register that every operation updates through its own write mask. The carry that enters add-with-carry and subtract-with-carry is the C bit currently held in that status register. Register file access and instruction decode are done elsewhere.

Requests arrive over a valid/ready handshake, and results leave over a second valid/ready handshake. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. A result is taken on an edge where `out_valid` and `out_ready` are both high. While a result waits with `out_ready` low, the result and the status bits stay frozen and `in_ready` stays low. Back-pressure therefore reaches the requester with no buffering inside the block. Byte operations finish in one cycle. Word operations work on the low byte in the acceptance cycle and on the high byte in the following cycle, and the block refuses new work during that second cycle. The status register changes only on the edge where a new result is loaded, so an operation that reads C always sees the flags left by the result before it.

Top module: `alu8_flagged`

## Requirements
- R1: `in_op` codes are: 0 add, 1 add with carry, 2 subtract, 3 subtract with carry, 4 compare, 5 compare with carry, 6 and, 7 or, 8 xor, 9 one's complement, 10 negate, 11 increment, 12 decrement, 13 set bits (a OR b), 14 clear bits (a AND NOT b), 15 test (result a), 16 set all (result 0xFF), 17 word add immediate, 18 word subtract immediate. Any other code yields a result with `out_wr` = 0 and the flags unchanged. Single-operand operations use `in_a`. For byte operations `out_hi` is 0, and `out_wr` is 1 except for the compares.
- R2: `flags` bit positions are C=0, Z=1, N=2, V=3, S=4, H=5. After reset `flags` is 0, `out_valid` is 0 and `in_ready` is 1.
- R3: A byte operation accepted on edge k gives `out_valid` after edge k. A word operation accepted on edge k holds `in_ready` and `out_valid` low in the next cycle and gives its result after edge k+1.
- R4: While `out_valid` is high and `out_ready` is low, `out_lo`, `out_hi`, `out_wr` and `flags` hold their values and `in_ready` is low. `flags` changes only together with a newly loaded result.
- R5: Add and subtract, with or without carry, compute a+b+C and a−b−C (C is taken as 0 for the plain forms). They write C (carry or borrow out of bit 7), H (carry or borrow out of bit 3), V (signed overflow), N (bit 7), Z and S.
- R6: For subtract with carry and compare with carry, Z becomes 0 when the result is nonzero and otherwise keeps its old value.
- R7: Compares set flags exactly as the matching subtract does and report `out_wr` = 0.
- R8: And, or, xor, set bits, clear bits and test write Z, N and S and clear V. C and H are unchanged.
- R9: One's complement gives 0xFF−a with C=1 and V=0. Negate gives 0x00−a with C=1 exactly when the result is nonzero and V=1 exactly when the result is 0x80. Both leave H unchanged.
- R10: Increment and decrement write Z, N and S. V is set by 0x7F→0x80 on increment and by 0x80→0x7F on decrement. C and H are unchanged.
- R11: Set all gives 0xFF and leaves every flag unchanged.
- R12: Word operations compute {in_hi,in_a} ± in_b[5:0] into {out_hi,out_lo}; bits 7:6 of `in_b` have no effect. They write C (carry or borrow out of bit 15), Z (all 16 bits zero), N (bit 15), V (16-bit signed overflow) and S. H is unchanged.
- R13: Whenever N or V is written, S is written as N xor V.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request this cycle |
| in_op | input | 5 | Operation code (R1) |
| in_a | input | 8 | First operand, or low byte of the pair |
| in_b | input | 8 | Second operand or immediate |
| in_hi | input | 8 | High byte of the pair for word operations |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_lo | output | 8 | Result byte, or low byte of the pair |
| out_hi | output | 8 | High byte of the word result, 0 otherwise |
| out_wr | output | 1 | Result is to be written back |
| flags | output | 6 | Status register (R2 layout) |

## Verification
The properties assume that `in_op` and the handshake inputs are known values on every clock edge after reset. They also assume that a compare or word code counts as accepted only on an edge where `in_ready` is high. They do not assume that the requester holds its fields steady, but the stimulus does so anyway: every field is held from the cycle `in_valid` rises until acceptance. Undefined codes are sent only deliberately. `out_ready` follows a repeating pattern that never stays low for more than two cycles, so both the stalled-hold rules and the word-operation gap are exercised.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [4:0] {
    OP_ADD    = 5'd0,
    OP_ADC    = 5'd1,
    OP_SUB    = 5'd2,
    OP_SBC    = 5'd3,
    OP_CMP    = 5'd4,
    OP_CMPC   = 5'd5,
    OP_AND    = 5'd6,
    OP_OR     = 5'd7,
    OP_XOR    = 5'd8,
    OP_COM    = 5'd9,
    OP_NEG    = 5'd10,
    OP_INC    = 5'd11,
    OP_DEC    = 5'd12,
    OP_SETB   = 5'd13,
    OP_CLRB   = 5'd14,
    OP_TST    = 5'd15,
    OP_SETALL = 5'd16,
    OP_WADD   = 5'd17,
    OP_WSUB   = 5'd18
  } alu_op_e;

  localparam int FLAG_W = 6;
  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;

  // write masks, bit order H S V N Z C
  localparam logic [FLAG_W-1:0] M_ARITH = 6'b111111;
  localparam logic [FLAG_W-1:0] M_CNZVS = 6'b011111;
  localparam logic [FLAG_W-1:0] M_NZVS  = 6'b011110;

  function automatic logic is_word_op(alu_op_e op);
    return (op == OP_WADD) || (op == OP_WSUB);
  endfunction

endpackage

// File: rtl/alu8_word_slice.sv
// Add or subtract of two W-bit values with carry in, carry/borrow out.
module alu8_word_slice #(
  parameter int W = 8
) (
  input  logic         sub,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] ext;
  logic [W:0] cin_ext;

  assign cin_ext = {{W{1'b0}}, cin};

  always_comb begin
    if (sub) ext = {1'b0, a} - {1'b0, b} - cin_ext;
    else     ext = {1'b0, a} + {1'b0, b} + cin_ext;
  end

  assign sum  = ext[W-1:0];
  assign cout = ext[W];
endmodule

// File: rtl/alu8_byte_unit.sv
// Single-cycle byte operations: result, write enable and masked flags.
module alu8_byte_unit
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e           op,
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  input  logic [FLAG_W-1:0] fl_old,
  output logic [W-1:0]      res,
  output logic [FLAG_W-1:0] fl_new,
  output logic              wr
);
  localparam int HW = W / 2;
  localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

  logic          sub_sel;
  logic          cin;
  logic          keep_z;
  logic [W-1:0]  ar_sum;
  logic          ar_c;
  logic [HW-1:0] hf_sum;
  logic          hf_c;

  assign sub_sel = op inside {OP_SUB, OP_SBC, OP_CMP, OP_CMPC};
  assign cin     = (op inside {OP_ADC, OP_SBC, OP_CMPC}) & fl_old[FL_C];
  assign keep_z  = op inside {OP_SBC, OP_CMPC};

  // full-width path gives C, lower-half path gives H
  alu8_word_slice #(.W(W)) i_full (
    .sub(sub_sel), .a(a), .b(b), .cin(cin), .sum(ar_sum), .cout(ar_c)
  );
  alu8_word_slice #(.W(HW)) i_half (
    .sub(sub_sel), .a(a[HW-1:0]), .b(b[HW-1:0]), .cin(cin),
    .sum(hf_sum), .cout(hf_c)
  );

  logic [FLAG_W-1:0] mask;
  logic [FLAG_W-1:0] fl_upd;
  logic              c_val, v_val, h_val, z_val, n_val;

  always_comb begin
    res   = a;
    wr    = 1'b1;
    mask  = '0;
    c_val = fl_old[FL_C];
    h_val = fl_old[FL_H];
    v_val = 1'b0;
    case (op)
      OP_ADD, OP_ADC: begin
        res   = ar_sum;
        mask  = M_ARITH;
        c_val = ar_c;
        h_val = hf_c;
        v_val = (a[W-1] == b[W-1]) && (ar_sum[W-1] != a[W-1]);
      end
      OP_SUB, OP_SBC, OP_CMP, OP_CMPC: begin
        res   = ar_sum;
        mask  = M_ARITH;
        c_val = ar_c;
        h_val = hf_c;
        v_val = (a[W-1] != b[W-1]) && (ar_sum[W-1] != a[W-1]);
        wr    = !(op inside {OP_CMP, OP_CMPC});
      end
      OP_AND:  begin res = a & b;  mask = M_NZVS; end
      OP_OR:   begin res = a | b;  mask = M_NZVS; end
      OP_XOR:  begin res = a ^ b;  mask = M_NZVS; end
      OP_SETB: begin res = a | b;  mask = M_NZVS; end
      OP_CLRB: begin res = a & ~b; mask = M_NZVS; end
      OP_TST:  begin res = a;      mask = M_NZVS; end
      OP_COM: begin
        res   = ~a;
        mask  = M_CNZVS;
        c_val = 1'b1;
      end
      OP_NEG: begin
        res   = '0 - a;
        mask  = M_CNZVS;
        c_val = |a;
        v_val = (a == MINV);
      end
      OP_INC: begin
        res   = a + ONE;
        mask  = M_NZVS;
        v_val = (a == MAXV);
      end
      OP_DEC: begin
        res   = a - ONE;
        mask  = M_NZVS;
        v_val = (a == MINV);
      end
      OP_SETALL: res = '1;
      default:   wr = 1'b0;
    endcase
    z_val  = (res == '0) && (!keep_z || fl_old[FL_Z]);
    n_val  = res[W-1];
    fl_upd = {h_val, n_val ^ v_val, v_val, n_val, z_val, c_val};
    fl_new = (fl_upd & mask) | (fl_old & ~mask);
  end
endmodule

// File: rtl/alu8_out_reg.sv
// Result and status register with valid/ready hold.
module alu8_out_reg #(
  parameter int W  = 8,
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  d_lo,
  input  logic [W-1:0]  d_hi,
  input  logic          d_wr,
  input  logic [FW-1:0] d_fl,
  input  logic          out_ready,
  output logic          q_valid,
  output logic [W-1:0]  q_lo,
  output logic [W-1:0]  q_hi,
  output logic          q_wr,
  output logic [FW-1:0] q_fl,
  output logic          free
);
  assign free = !q_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_lo    <= '0;
      q_hi    <= '0;
      q_wr    <= 1'b0;
      q_fl    <= '0;
    end else if (load) begin
      q_valid <= 1'b1;
      q_lo    <= d_lo;
      q_hi    <= d_hi;
      q_wr    <= d_wr;
      q_fl    <= d_fl;
    end else if (out_ready) begin
      q_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/alu8_flagged.sv
module alu8_flagged
  import alu8_pkg::*;
#(
  parameter int W  = 8,
  parameter int KW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [4:0]        in_op,
  input  logic [W-1:0]      in_a,
  input  logic [W-1:0]      in_b,
  input  logic [W-1:0]      in_hi,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [W-1:0]      out_lo,
  output logic [W-1:0]      out_hi,
  output logic              out_wr,
  output logic [FLAG_W-1:0] flags
);
  localparam int PAD = W - KW;

  alu_op_e op_e;
  logic    op_word;
  logic    out_free;
  logic    busy_q;
  logic    take, byte_go, word_go, word_fin, load;

  assign op_e     = alu_op_e'(in_op);
  assign op_word  = is_word_op(op_e);
  assign in_ready = !busy_q && out_free;
  assign take     = in_valid && in_ready;
  assign byte_go  = take && !op_word;
  assign word_go  = take && op_word;
  assign word_fin = busy_q && out_free;
  assign load     = byte_go || word_fin;

  // byte path
  logic [W-1:0]      b_res;
  logic [FLAG_W-1:0] b_fl;
  logic              b_wr;

  alu8_byte_unit #(.W(W)) i_byte (
    .op(op_e), .a(in_a), .b(in_b), .fl_old(flags),
    .res(b_res), .fl_new(b_fl), .wr(b_wr)
  );

  // word path, first half: low byte against the zero-extended immediate
  logic [W-1:0] lo_sum;
  logic         lo_c;
  logic [W-1:0] imm_ext;

  assign imm_ext = {{PAD{1'b0}}, in_b[KW-1:0]};

  alu8_word_slice #(.W(W)) i_lo (
    .sub(op_e == OP_WSUB), .a(in_a), .b(imm_ext), .cin(1'b0),
    .sum(lo_sum), .cout(lo_c)
  );

  logic [W-1:0] w_lo_q, w_hi_q;
  logic         w_c_q, w_sub_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      w_lo_q  <= '0;
      w_hi_q  <= '0;
      w_c_q   <= 1'b0;
      w_sub_q <= 1'b0;
    end else if (word_go) begin
      busy_q  <= 1'b1;
      w_lo_q  <= lo_sum;
      w_hi_q  <= in_hi;
      w_c_q   <= lo_c;
      w_sub_q <= (op_e == OP_WSUB);
    end else if (word_fin) begin
      busy_q  <= 1'b0;
    end
  end

  // word path, second half: high byte absorbs the low carry or borrow
  logic [W-1:0]      hi_sum;
  logic              hi_c;
  logic [FLAG_W-1:0] w_fl;
  logic              w_n, w_v;

  alu8_word_slice #(.W(W)) i_hi (
    .sub(w_sub_q), .a(w_hi_q), .b('0), .cin(w_c_q),
    .sum(hi_sum), .cout(hi_c)
  );

  always_comb begin
    w_n = hi_sum[W-1];
    if (w_sub_q) w_v = w_hi_q[W-1] && !hi_sum[W-1];
    else         w_v = !w_hi_q[W-1] && hi_sum[W-1];
    w_fl       = flags;
    w_fl[FL_C] = hi_c;
    w_fl[FL_Z] = ({hi_sum, w_lo_q} == '0);
    w_fl[FL_N] = w_n;
    w_fl[FL_V] = w_v;
    w_fl[FL_S] = w_n ^ w_v;
  end

  alu8_out_reg #(.W(W), .FW(FLAG_W)) i_out (
    .clk(clk), .rst_n(rst_n), .load(load),
    .d_lo(busy_q ? w_lo_q : b_res),
    .d_hi(busy_q ? hi_sum : '0),
    .d_wr(busy_q ? 1'b1 : b_wr),
    .d_fl(busy_q ? w_fl : b_fl),
    .out_ready(out_ready),
    .q_valid(out_valid), .q_lo(out_lo), .q_hi(out_hi),
    .q_wr(out_wr), .q_fl(flags), .free(out_free)
  );
endmodule

// File: rtl/alu8_flagged_chk.sv
module alu8_flagged_chk
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [4:0]        in_op,
  input logic              out_valid,
  input logic              out_ready,
  input logic [W-1:0]      out_lo,
  input logic [W-1:0]      out_hi,
  input logic              out_wr,
  input logic [FLAG_W-1:0] flags
);
  logic take, take_word, take_cmp;

  assign take      = in_valid && in_ready;
  assign take_word = take && ((in_op == 5'(OP_WADD)) || (in_op == 5'(OP_WSUB)));
  assign take_cmp  = take && ((in_op == 5'(OP_CMP)) || (in_op == 5'(OP_CMPC)));

  a_r3_byte_latency: assert property (@(posedge clk) disable iff (!rst_n)
    take && !take_word |=> out_valid);

  a_r3_word_gap: assert property (@(posedge clk) disable iff (!rst_n)
    take_word |=> !in_ready && !out_valid);

  a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_lo) && $stable(out_hi)
                                && $stable(out_wr) && $stable(flags));

  a_r4_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  a_r4_flags_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(flags) |-> out_valid);

  a_r7_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    take_cmp |=> out_valid && !out_wr);

  a_r13_sign_rule: assert property (@(posedge clk) disable iff (!rst_n)
    flags[FL_S] == (flags[FL_N] ^ flags[FL_V]));
endmodule

bind alu8_flagged alu8_flagged_chk #(.W(W)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .out_valid(out_valid), .out_ready(out_ready),
  .out_lo(out_lo), .out_hi(out_hi), .out_wr(out_wr), .flags(flags)
);

// File: tb/test_alu8_flagged.sv
module test_alu8_flagged;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  typedef struct packed {
    logic [4:0] op;
    logic [7:0] lo;
    logic [7:0] hi;
    logic       wr;
    logic [5:0] fl;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [4:0] in_op = '0;
  logic [7:0] in_a = '0, in_b = '0, in_hi = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_lo, out_hi;
  logic       out_wr;
  logic [5:0] flags;

  int   checks = 0;
  int   errors = 0;
  bit   stall_en = 0;
  int   rdy_cnt = 0;
  logic [5:0] mf = '0;
  logic [31:0] rng = 32'h1bad5eed;
  exp_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  alu8_flagged i_alu8_flagged (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_hi(in_hi),
    .out_valid(out_valid), .out_ready(out_ready), .out_lo(out_lo),
    .out_hi(out_hi), .out_wr(out_wr), .flags(flags)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  function automatic string rtag(input logic [4:0] op);
    case (op)
      5'd0, 5'd1, 5'd2:                   return "R5";
      5'd3, 5'd5:                         return "R6";
      5'd4:                               return "R7";
      5'd6, 5'd7, 5'd8, 5'd13, 5'd14, 5'd15: return "R8";
      5'd9, 5'd10:                        return "R9";
      5'd11, 5'd12:                       return "R10";
      5'd16:                              return "R11";
      5'd17, 5'd18:                       return "R12";
      default:                            return "R1";
    endcase
  endfunction

  // reference model from the requirements, integer arithmetic
  function automatic exp_t model(input logic [4:0] op, input logic [7:0] a,
                                 input logic [7:0] b, input logic [7:0] h,
                                 input logic [5:0] f);
    exp_t e;
    int ua, ub, sa, sb, t, sv, hn, r, cin, p, sp, k, t16;
    logic c, v, hc, z, n;
    bit up_c, up_h, up_nzvs, wide;
    e.op = op; e.hi = 8'h00; e.wr = 1'b1; e.fl = f;
    ua = int'(a); ub = int'(b); sa = int'($signed(a)); sb = int'($signed(b));
    c = f[0]; hc = f[5]; v = 1'b0; r = ua; t16 = 0;
    up_c = 0; up_h = 0; up_nzvs = 0; wide = 0;
    case (op)
      5'd0, 5'd1, 5'd2, 5'd3, 5'd4, 5'd5: begin
        cin = (op == 5'd1 || op == 5'd3 || op == 5'd5) ? int'(f[0]) : 0;
        if (op <= 5'd1) begin
          t = ua + ub + cin; hn = (ua % 16) + (ub % 16) + cin;
          c = (t > 255); hc = (hn > 15); sv = sa + sb + cin;
        end else begin
          t = ua - ub - cin; hn = (ua % 16) - (ub % 16) - cin;
          c = (t < 0); hc = (hn < 0); sv = sa - sb - cin;
        end
        r = t & 255; v = (sv > 127) || (sv < -128);
        up_c = 1; up_h = 1; up_nzvs = 1;
        if (op >= 5'd4) e.wr = 1'b0;
      end
      5'd6:  begin r = ua & ub; up_nzvs = 1; end
      5'd7:  begin r = ua | ub; up_nzvs = 1; end
      5'd8:  begin r = ua ^ ub; up_nzvs = 1; end
      5'd13: begin r = ua | ub; up_nzvs = 1; end
      5'd14: begin r = ua & (255 - ub); up_nzvs = 1; end
      5'd15: begin r = ua; up_nzvs = 1; end
      5'd9:  begin r = 255 - ua; c = 1'b1; up_c = 1; up_nzvs = 1; end
      5'd10: begin r = (256 - ua) & 255; c = (ua != 0); v = (ua == 128); up_c = 1; up_nzvs = 1; end
      5'd11: begin r = (ua + 1) & 255; v = (sa + 1 > 127); up_nzvs = 1; end
      5'd12: begin r = (ua + 255) & 255; v = (sa - 1 < -128); up_nzvs = 1; end
      5'd16: r = 255;
      5'd17, 5'd18: begin
        k = ub % 64; p = int'(h) * 256 + ua; sp = int'($signed({h, a}));
        if (op == 5'd17) begin t = p + k; c = (t > 65535); sv = sp + k; end
        else             begin t = p - k; c = (t < 0);     sv = sp - k; end
        t16 = t & 65535; r = t16 & 255; e.hi = 8'(t16 / 256);
        v = (sv > 32767) || (sv < -32768);
        up_c = 1; up_nzvs = 1; wide = 1;
      end
      default: e.wr = 1'b0;
    endcase
    if (wide) begin n = (t16 >= 32768); z = (t16 == 0); end
    else begin
      n = (r >= 128); z = (r == 0);
      if (op == 5'd3 || op == 5'd5) z = z && f[1];
    end
    if (up_nzvs) begin e.fl[1] = z; e.fl[2] = n; e.fl[3] = v; e.fl[4] = n ^ v; end
    if (up_c) e.fl[0] = c;
    if (up_h) e.fl[5] = hc;
    e.lo = 8'(r);
    return e;
  endfunction

  // driver: present, wait for acceptance, push the expected item
  task automatic send(input logic [4:0] op, input logic [7:0] a,
                      input logic [7:0] b, input logic [7:0] h);
    exp_t e;
    bit   wd;
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_hi = h;
    while (!in_ready) @(negedge clk);
    e = model(op, a, b, h, mf);
    mf = e.fl;
    exp_q.push_back(e);
    wd = (op == 5'd17 || op == 5'd18);
    @(negedge clk);
    in_valid = 1'b0;
    if (wd) begin
      chk(in_ready == 1'b0, "R3", "in_ready in word second cycle", 32'(in_ready), 0);
      if (!stall_en) begin
        chk(out_valid == 1'b0, "R3", "out_valid in word second cycle", 32'(out_valid), 0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R3", "word result after two cycles", 32'(out_valid), 1);
      end
    end else if (!stall_en) begin
      chk(out_valid == 1'b1, "R3", "byte result after one cycle", 32'(out_valid), 1);
    end
  endtask

  // out_ready pattern, changed just after the edge
  always @(posedge clk) begin
    #1;
    rdy_cnt++;
    out_ready = stall_en ? ((rdy_cnt % 5) < 3) : 1'b1;
  end

  // monitor: hold rule and scoreboard compare
  logic        held_v = 1'b0;
  logic [22:0] held_d = '0;
  always @(negedge clk) begin
    exp_t e;
    if (rst_n) begin
      if (held_v) begin
        chk(out_valid && ({out_hi, out_lo, out_wr, flags} == held_d), "R4",
            "stalled output held", 32'({out_hi, out_lo, out_wr, flags}), 32'(held_d));
        chk(in_ready == 1'b0 || !out_valid || out_ready, "R4",
            "in_ready while stalled", 32'(in_ready), 0);
      end
      held_v = out_valid && !out_ready;
      held_d = {out_hi, out_lo, out_wr, flags};
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3", "output with nothing pending", 32'(out_lo), 0);
        end else begin
          e = exp_q.pop_front();
          chk({out_hi, out_lo, out_wr, flags} == {e.hi, e.lo, e.wr, e.fl}, rtag(e.op),
              $sformatf("op %0d hi/lo/wr/flags", e.op),
              32'({out_hi, out_lo, out_wr, flags}), 32'({e.hi, e.lo, e.wr, e.fl}));
          chk(flags[4] == (flags[2] ^ flags[3]), "R13", "S equals N xor V",
              32'(flags), 32'(e.fl));
        end
      end
    end
  end

  task automatic step_rng();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R2", "out_valid after reset", 32'(out_valid), 0);
    chk(flags == 6'd0, "R2", "flags after reset", 32'(flags), 0);
    chk(in_ready == 1'b1, "R2", "in_ready after reset", 32'(in_ready), 1);

    // R5 add and subtract corners
    send(5'd0, 8'h0F, 8'h01, 8'h00);
    send(5'd0, 8'h7F, 8'h01, 8'h00);
    send(5'd0, 8'hFF, 8'h01, 8'h00);
    send(5'd1, 8'h10, 8'h20, 8'h00);
    send(5'd2, 8'h00, 8'h01, 8'h00);
    send(5'd2, 8'h80, 8'h01, 8'h00);
    // R6 sticky zero
    send(5'd2, 8'h05, 8'h05, 8'h00);
    send(5'd5, 8'h05, 8'h05, 8'h00);
    send(5'd5, 8'h06, 8'h05, 8'h00);
    send(5'd5, 8'h05, 8'h05, 8'h00);
    send(5'd3, 8'h40, 8'h3F, 8'h00);
    // R7 compare
    send(5'd4, 8'h10, 8'h20, 8'h00);
    send(5'd4, 8'h33, 8'h33, 8'h00);
    // R8 logic keeps C and H
    send(5'd0, 8'h0F, 8'hF1, 8'h00);
    send(5'd6, 8'hF0, 8'h0F, 8'h00);
    send(5'd7, 8'h80, 8'h01, 8'h00);
    send(5'd8, 8'hAA, 8'hAA, 8'h00);
    send(5'd13, 8'h01, 8'h80, 8'h00);
    send(5'd14, 8'hFF, 8'h0F, 8'h00);
    send(5'd15, 8'h00, 8'hFF, 8'h00);
    // R9, R10
    send(5'd9, 8'h00, 8'h00, 8'h00);
    send(5'd10, 8'h00, 8'h00, 8'h00);
    send(5'd10, 8'h80, 8'h00, 8'h00);
    send(5'd10, 8'h01, 8'h00, 8'h00);
    send(5'd11, 8'h7F, 8'h00, 8'h00);
    send(5'd11, 8'hFF, 8'h00, 8'h00);
    send(5'd12, 8'h80, 8'h00, 8'h00);
    send(5'd12, 8'h00, 8'h00, 8'h00);
    // R11 set all leaves flags
    send(5'd16, 8'h12, 8'h34, 8'h00);
    // R12 word operations
    send(5'd17, 8'hFF, 8'h01, 8'h00);
    send(5'd17, 8'hFF, 8'h01, 8'h7F);
    send(5'd17, 8'hFF, 8'h01, 8'hFF);
    send(5'd18, 8'h00, 8'h01, 8'h00);
    send(5'd18, 8'h00, 8'h01, 8'h80);
    send(5'd17, 8'h10, 8'hC1, 8'h22);
    send(5'd18, 8'h3F, 8'hFF, 8'h01);
    // R1 undefined code
    send(5'd25, 8'h5A, 8'hA5, 8'h00);

    // mixed traffic under back-pressure
    stall_en = 1;
    for (int i = 0; i < 400; i++) begin
      logic [4:0] op;
      step_rng();
      op = 5'(rng[31:8] % 20);
      send(op, rng[7:0], rng[15:8], rng[23:16]);
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    bit done;
    done = 0;
    fork
      begin run_all(); done = 1; end
      begin repeat (WATCHDOG) @(posedge clk); end
    join_any
    disable fork;
    if (!done) chk(1'b0, "R3", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule